// File: doc/BRIEF.md
# Serial Channel Register Core

This block holds the register state of a single channel of a multi-channel serial controller. A host reaches it over an 8-bit register bus with four addresses. Those addresses hold two mode bytes that share one location, a status byte, a command byte and a holding location. A write to the holding location sends a byte to the transmitter. A read from it takes a byte out of the receive queue. The bit-level line, baud timing and modem-control outputs live elsewhere. Here, received characters arrive on a valid/ready byte stream, transmitted characters leave as a one-cycle strobe with data, and a line break arrives as a single-cycle pulse.

Inside the block, a three-entry receive queue only takes bytes while the receiver is on and a slot is free. Break status is handled in two phases. The first break raises a request at once. When the host later reads a character while the break flag is still set, the flag clears and the request is raised again. Three request flags (transmitter ready, receive data present, break) go to the shared interrupt logic.

Top module: `uart_chan_regs`

## Requirements
- R1: Out of reset the status byte reads 0, rx_ready, tx_valid and all three request outputs are low, the receive queue is empty, and the mode pointer selects the first mode byte.
- R2: A write to address 2 is a command. Bit 0 turns the receiver on, bit 1 turns it off, bit 2 turns the transmitter on and bit 3 turns it off. When both bits of a pair are set, off wins. While the receiver is off, offered bytes are ignored.
- R3: Turning the transmitter on sets status bits 2 and 3 and irq_txrdy. Turning it off, or command code 3 (bits 7:4), clears all three.
- R4: Address 0 reaches the mode byte that the pointer selects, for both reads and writes. Every access then moves the pointer to the second byte. Command code 1 moves it back to the first.
- R5: The queue holds 3 bytes. rx_ready is high only while the receiver is on, fewer than 3 bytes are stored and no break pulse is present. Status bit 1 is set while 3 bytes are stored.
- R6: Status bit 0 and irq_rxrdy are high while the queue is not empty. A read of address 3 returns the oldest byte and removes it, so bytes come out in arrival order.
- R7: A byte offered while the receiver is on and the queue is full, or a break while the queue is full, is discarded and sets status bit 4. Command code 4 clears status bits 4 to 7.
- R8: Command code 2 turns the receiver off and empties the queue, which clears status bit 0 and irq_rxrdy.
- R9: A break pulse pushes a zero byte. If status bit 7 was clear, the pulse also sets bit 7 and irq_brk. Command code 5 clears irq_brk but leaves bit 7 as it is.
- R10: A read of address 3 that removes a byte while status bit 7 is set clears bit 7 and raises irq_brk.
- R11: A write to address 3 while the transmitter is ready drives tx_valid for one cycle on the next cycle, with that byte on tx_data. When the transmitter is not ready, the write is dropped.
- R12: Command codes 0 and 6 to 15 change nothing beyond what their low bits do, and writes to address 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address: 0 mode, 1 status, 2 command, 3 holding |
| reg_wr | input | 1 | Write strobe; takes priority over reg_rd |
| reg_rd | input | 1 | Read strobe; side effects at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address (combinational) |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Channel can take a byte this cycle |
| brk_pulse | input | 1 | Line break detected (one-cycle pulse) |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq_txrdy | output | 1 | Transmitter ready request |
| irq_rxrdy | output | 1 | Receive data present request |
| irq_brk | output | 1 | Break request |

## Verification
The hardest state to reach is a full queue that already holds a break byte, with the overrun and break flags both set and the mode pointer parked on its second byte. Every command value then has to be judged against that state. The bench builds this state again before each of the 256 command writes. It clears the receiver, re-enables it, injects a break, offers three more bytes so the last one overruns, and touches the mode address. It then checks status, requests, mode read-back and a transmit attempt against values worked out from the command bits.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_STAT = 2'd1,
    A_CMD  = 2'd2,
    A_HOLD = 2'd3
  } reg_addr_e;

  typedef enum logic [3:0] {
    C_NOP     = 4'd0,
    C_PTR_RST = 4'd1,
    C_RX_RST  = 4'd2,
    C_TX_RST  = 4'd3,
    C_ERR_RST = 4'd4,
    C_BRK_RST = 4'd5
  } cmd_code_e;

  localparam int SB_RXRDY = 0;
  localparam int SB_FULL  = 1;
  localparam int SB_TXRDY = 2;
  localparam int SB_TXEMT = 3;
  localparam int SB_OVR   = 4;
  localparam int SB_PAR   = 5;
  localparam int SB_FRM   = 6;
  localparam int SB_BRK   = 7;

  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic logic [7:0] pack_status(input logic rxrdy, input logic full,
                                             input logic txrdy, input logic ovr,
                                             input logic brk);
    logic [7:0] s;
    s = '0;
    s[SB_RXRDY] = rxrdy;
    s[SB_FULL]  = full;
    s[SB_TXRDY] = txrdy;
    s[SB_TXEMT] = txrdy;
    s[SB_OVR]   = ovr;
    s[SB_PAR]   = 1'b0;
    s[SB_FRM]   = 1'b0;
    s[SB_BRK]   = brk;
    return s;
  endfunction

endpackage

// File: rtl/uart_chan_cmd_dec.sv
module uart_chan_cmd_dec
  import uart_chan_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output logic       rx_on,
  output logic       rx_off,
  output logic       tx_on,
  output logic       tx_off,
  output logic       do_ptr_rst,
  output logic       do_rx_rst,
  output logic       do_tx_rst,
  output logic       do_err_rst,
  output logic       do_brk_rst
);
  cmd_code_e code;

  always_comb begin
    code       = cmd_code_e'(cmd_byte[7:4]);
    rx_on      = cmd_wr && cmd_byte[0];
    rx_off     = cmd_wr && cmd_byte[1];
    tx_on      = cmd_wr && cmd_byte[2];
    tx_off     = cmd_wr && cmd_byte[3];
    do_ptr_rst = 1'b0;
    do_rx_rst  = 1'b0;
    do_tx_rst  = 1'b0;
    do_err_rst = 1'b0;
    do_brk_rst = 1'b0;
    if (cmd_wr) begin
      case (code)
        C_PTR_RST: do_ptr_rst = 1'b1;
        C_RX_RST:  do_rx_rst  = 1'b1;
        C_TX_RST:  do_tx_rst  = 1'b1;
        C_ERR_RST: do_err_rst = 1'b1;
        C_BRK_RST: do_brk_rst = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/uart_chan_mode_regs.sv
module uart_chan_mode_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          access,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ptr_rst,
  output logic [DW-1:0] rdata,
  output logic          ptr
);
  logic [DW-1:0] mode_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      ptr       <= 1'b0;
    end else begin
      if (access && wr) mode_q[ptr] <= wdata;
      if (access) ptr <= 1'b1;
      else if (ptr_rst) ptr <= 1'b0;
    end
  end

  assign rdata = mode_q[ptr];
endmodule

// File: rtl/uart_chan_rxfifo.sv
module uart_chan_rxfifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != FULLV);
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= PW'(uart_chan_pkg::ptr_next(32'(wr_ptr), DEPTH));
      end
      if (do_pop) rd_ptr <= PW'(uart_chan_pkg::ptr_next(32'(rd_ptr), DEPTH));
      count <= CW'(count + CW'(do_push) - CW'(do_pop));
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_chan_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          brk_pulse,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          irq_txrdy,
  output logic          irq_rxrdy,
  output logic          irq_brk
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] FULLV = CW'(FIFO_DEPTH);

  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr);

  // state
  logic rx_en_q, tx_rdy_q, ovr_q, brk_q, irq_brk_q;
  logic rx_en_n, tx_rdy_n, ovr_n, brk_n, irq_brk_n;

  // bus decode
  logic cmd_wr, hold_wr, hold_rd, mode_acc;
  assign cmd_wr   = reg_wr && (addr == A_CMD);
  assign hold_wr  = reg_wr && (addr == A_HOLD);
  assign hold_rd  = reg_rd && !reg_wr && (addr == A_HOLD);
  assign mode_acc = (reg_wr || reg_rd) && (addr == A_MODE);

  // command decode
  logic rx_on, rx_off, tx_on, tx_off;
  logic do_ptr_rst, do_rx_rst, do_tx_rst, do_err_rst, do_brk_rst;

  uart_chan_cmd_dec u_cmd (
    .cmd_wr    (cmd_wr),
    .cmd_byte  (reg_wdata[7:0]),
    .rx_on     (rx_on),
    .rx_off    (rx_off),
    .tx_on     (tx_on),
    .tx_off    (tx_off),
    .do_ptr_rst(do_ptr_rst),
    .do_rx_rst (do_rx_rst),
    .do_tx_rst (do_tx_rst),
    .do_err_rst(do_err_rst),
    .do_brk_rst(do_brk_rst)
  );

  // mode registers
  logic [DW-1:0] mode_rdata;
  logic          mode_ptr;

  uart_chan_mode_regs #(.DW(DW)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .access (mode_acc),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .ptr_rst(do_ptr_rst),
    .rdata  (mode_rdata),
    .ptr    (mode_ptr)
  );

  // receive queue and named events
  logic [CW-1:0] fifo_cnt;
  logic [DW-1:0] fifo_head, push_data;
  logic          fifo_full, fifo_empty;
  logic          ev_push, ev_pop, ev_overrun, ev_brk_set, ev_brk_defer, ev_rx_take;

  assign fifo_full    = (fifo_cnt == FULLV);
  assign fifo_empty   = (fifo_cnt == '0);
  assign rx_ready     = rx_en_q && !fifo_full && !brk_pulse;
  assign ev_rx_take   = rx_valid && rx_ready;
  assign ev_push      = (brk_pulse && !fifo_full) || ev_rx_take;
  assign ev_overrun   = fifo_full && (brk_pulse || (rx_valid && rx_en_q));
  assign ev_pop       = hold_rd && !fifo_empty;
  assign ev_brk_set   = brk_pulse && !brk_q;
  assign ev_brk_defer = ev_pop && brk_q;
  assign push_data    = brk_pulse ? '0 : rx_data;

  uart_chan_rxfifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (do_rx_rst),
    .push     (ev_push),
    .push_data(push_data),
    .pop      (ev_pop),
    .head     (fifo_head),
    .count    (fifo_cnt)
  );

  // next state
  always_comb begin
    rx_en_n = rx_en_q;
    if (rx_on)     rx_en_n = 1'b1;
    if (rx_off)    rx_en_n = 1'b0;
    if (do_rx_rst) rx_en_n = 1'b0;

    tx_rdy_n = tx_rdy_q;
    if (tx_on)     tx_rdy_n = 1'b1;
    if (tx_off)    tx_rdy_n = 1'b0;
    if (do_tx_rst) tx_rdy_n = 1'b0;

    ovr_n = ovr_q;
    if (ev_overrun) ovr_n = 1'b1;
    if (do_err_rst) ovr_n = 1'b0;

    brk_n = brk_q;
    if (ev_brk_defer) brk_n = 1'b0;
    if (ev_brk_set)   brk_n = 1'b1;
    if (do_err_rst)   brk_n = 1'b0;

    irq_brk_n = irq_brk_q;
    if (ev_brk_set || ev_brk_defer) irq_brk_n = 1'b1;
    if (do_brk_rst)                 irq_brk_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q   <= 1'b0;
      tx_rdy_q  <= 1'b0;
      ovr_q     <= 1'b0;
      brk_q     <= 1'b0;
      irq_brk_q <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      rx_en_q   <= rx_en_n;
      tx_rdy_q  <= tx_rdy_n;
      ovr_q     <= ovr_n;
      brk_q     <= brk_n;
      irq_brk_q <= irq_brk_n;
      tx_valid  <= hold_wr && tx_rdy_q;
      if (hold_wr && tx_rdy_q) tx_data <= reg_wdata;
    end
  end

  // read mux
  logic [7:0] status;
  assign status = pack_status(!fifo_empty, fifo_full, tx_rdy_q, ovr_q, brk_q);

  always_comb begin
    case (addr)
      A_MODE:  reg_rdata = mode_rdata;
      A_STAT:  reg_rdata = DW'(status);
      A_HOLD:  reg_rdata = fifo_head;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_txrdy = tx_rdy_q;
  assign irq_rxrdy = !fifo_empty;
  assign irq_brk   = irq_brk_q;
endmodule

// File: rtl/uart_chan_regs_chk.sv
module uart_chan_regs_chk #(
  parameter int DW = 8,
  parameter int CW = 2,
  parameter int FIFO_DEPTH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          irq_txrdy,
  input logic          irq_rxrdy,
  input logic          irq_brk,
  input logic [CW-1:0] fifo_cnt,
  input logic          ev_pop,
  input logic          ev_overrun,
  input logic          brk_q,
  input logic          ovr_q,
  input logic          mode_ptr,
  input logic          mode_acc
);
  logic cmd_w;
  assign cmd_w = reg_wr && (reg_addr == 2'd2);

  p_txrdy_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && reg_wdata[2] && !reg_wdata[3] && reg_wdata[7:4] != 4'd3) |=> irq_txrdy);

  p_txrdy_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && (reg_wdata[3] || reg_wdata[7:4] == 4'd3)) |=> !irq_txrdy);

  p_mode_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_acc |=> mode_ptr);

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(FIFO_DEPTH)) |-> !rx_ready);

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overrun && !(cmd_w && reg_wdata[7:4] == 4'd4)) |=> ovr_q);

  p_reset_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && reg_wdata[7:4] == 4'd2) |=> (!irq_rxrdy && !rx_ready));

  p_brk_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && brk_q) |=> (irq_brk && !brk_q));

  p_tx_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && !irq_txrdy) |=> !tx_valid);

  p_tx_send_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && irq_txrdy) |=> (tx_valid && tx_data == $past(reg_wdata)));
endmodule

bind uart_chan_regs uart_chan_regs_chk #(.DW(DW), .CW(CW), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .irq_txrdy (irq_txrdy),
  .irq_rxrdy (irq_rxrdy),
  .irq_brk   (irq_brk),
  .fifo_cnt  (fifo_cnt),
  .ev_pop    (ev_pop),
  .ev_overrun(ev_overrun),
  .brk_q     (brk_q),
  .ovr_q     (ovr_q),
  .mode_ptr  (mode_ptr),
  .mode_acc  (mode_acc)
);

// File: tb/uart_chan_regs_tb.sv
module uart_chan_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, brk_pulse = 1'b0, tx_valid;
  logic [7:0] tx_data;
  logic       irq_txrdy, irq_rxrdy, irq_brk;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_chan_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .brk_pulse(brk_pulse), .tx_valid(tx_valid), .tx_data(tx_data),
    .irq_txrdy(irq_txrdy), .irq_rxrdy(irq_rxrdy), .irq_brk(irq_brk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk);
    brk_pulse = 1'b1;
    @(negedge clk);
    brk_pulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, d);
    chk("R1 status", d, 8'h00);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 irqs", {irq_txrdy, irq_rxrdy, irq_brk, tx_valid}, 4'b0000);

    // R4 mode pointer (first write lands in entry 0 proves reset pointer, R1)
    wr(2'd0, 8'h11);
    wr(2'd0, 8'h22);
    wr(2'd2, 8'h10);
    rd(2'd0, d); chk("R4 mode first", d, 8'h11);
    rd(2'd0, d); chk("R4 mode second", d, 8'h22);
    rd(2'd0, d); chk("R4 mode stays second", d, 8'h22);

    // R2 receiver off ignores bytes
    push(8'h77);
    rd(2'd1, d); chk("R2 rx off ignored", d, 8'h00);
    chk("R2 irq_rxrdy", irq_rxrdy, 0);

    // R12 status write ignored
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R12 status write", d, 8'h00);

    // R5 / R6 queue order and flags
    wr(2'd2, 8'h01);
    chk("R5 ready when on", rx_ready, 1);
    push(8'hA1); push(8'hB2);
    rd(2'd1, d); chk("R6 rxrdy", d, 8'h01);
    push(8'hC3);
    rd(2'd1, d); chk("R5 full", d, 8'h03);
    chk("R5 ready low full", rx_ready, 0);
    rd(2'd3, d); chk("R6 pop1", d, 8'hA1);
    rd(2'd3, d); chk("R6 pop2", d, 8'hB2);
    rd(2'd1, d); chk("R6 one left", d, 8'h01);
    rd(2'd3, d); chk("R6 pop3", d, 8'hC3);
    rd(2'd1, d); chk("R6 empty", d, 8'h00);
    chk("R6 irq_rxrdy clear", irq_rxrdy, 0);

    // R7 overrun
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    rd(2'd1, d); chk("R7 overrun set", d, 8'h13);
    wr(2'd2, 8'h40);
    rd(2'd1, d); chk("R7 error reset", d, 8'h03);
    rd(2'd3, d); rd(2'd3, d); rd(2'd3, d);
    chk("R7 dropped byte", d, 8'h03);
    rd(2'd1, d); chk("R7 drained", d, 8'h00);

    // R8 receiver reset
    push(8'h55); push(8'h66);
    wr(2'd2, 8'h20);
    rd(2'd1, d); chk("R8 emptied", d, 8'h00);
    chk("R8 rx off", rx_ready, 0);
    push(8'h99);
    rd(2'd1, d); chk("R8 stays off", d, 8'h00);
    wr(2'd2, 8'h01);

    // R9 / R10 break
    brk();
    rd(2'd1, d); chk("R9 break status", d, 8'h81);
    chk("R9 irq_brk set", irq_brk, 1);
    wr(2'd2, 8'h50);
    chk("R9 irq_brk cleared", irq_brk, 0);
    rd(2'd1, d); chk("R9 bit kept", d, 8'h81);
    brk();
    chk("R9 no second raise", irq_brk, 0);
    rd(2'd3, d); chk("R9 zero byte", d, 8'h00);
    chk("R10 deferred raise", irq_brk, 1);
    rd(2'd1, d); chk("R10 bit cleared", d, 8'h01);
    wr(2'd2, 8'h50);
    rd(2'd3, d);
    chk("R10 no raise without bit", irq_brk, 0);

    // R11 / R3 transmit
    wr(2'd3, 8'h5A);
    chk("R11 dropped", tx_valid, 0);
    wr(2'd2, 8'h04);
    rd(2'd1, d); chk("R3 tx on status", d, 8'h0C);
    chk("R3 irq_txrdy", irq_txrdy, 1);
    wr(2'd3, 8'h5A);
    chk("R11 sent", {tx_valid, tx_data}, {1'b1, 8'h5A});
    @(negedge clk);
    chk("R11 single strobe", tx_valid, 0);
    wr(2'd2, 8'h30);
    chk("R3 tx reset", irq_txrdy, 0);
    wr(2'd2, 8'h05);
    wr(2'd2, 8'h0F);
    rd(2'd1, d); chk("R2 off wins", d, 8'h00);
    chk("R2 rx off wins", rx_ready, 0);

    // sweep of every command byte from a loaded state
    for (int v = 0; v < 256; v++) begin
      logic [3:0] code;
      logic tx_e, q_e, err_e, brk_e;
      logic [7:0] cv;
      cv = 8'(v);
      code = cv[7:4];
      wr(2'd2, 8'h20);
      wr(2'd2, 8'h45);
      wr(2'd2, 8'h50);
      brk();
      push(8'h10); push(8'h20); push(8'h30);
      rd(2'd0, d);
      wr(2'd2, cv);
      tx_e  = !cv[3] && code != 4'd3;
      q_e   = code != 4'd2;
      err_e = code != 4'd4;
      brk_e = code != 4'd5;
      rd(2'd1, d);
      chk($sformatf("R12 sweep status cmd %0h", v), d,
          {err_e, 2'b00, err_e, tx_e, tx_e, q_e, q_e});
      chk($sformatf("R12 sweep irqs cmd %0h", v), {irq_txrdy, irq_rxrdy, irq_brk},
          {tx_e, q_e, brk_e});
      rd(2'd0, d);
      chk($sformatf("R4 sweep mode cmd %0h", v), d, (code == 4'd1) ? 8'h11 : 8'h22);
      wr(2'd3, cv);
      chk($sformatf("R11 sweep tx cmd %0h", v), {tx_valid, tx_valid ? tx_data : 8'h00},
          {tx_e, tx_e ? cv : 8'h00});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule